// File: doc/BRIEF.md
# Gated Programmable Clock Divider

This block is one clock channel for a peripheral. It runs entirely in the domain of a single reference clock. It does not produce a second clock. Instead it produces a one-cycle enable strobe, `clk_strobe`, once every N reference cycles. Downstream logic qualifies its flops with this strobe. The channel has a small register port. Software can gate the strobe with an enable bit. It can program the divide ratio in two ways: it can write a raw field code, or it can ask a built-in encoder to convert a plain ratio into a code. A ratio the field cannot represent is rejected.

The field is the written data masked to `FIELD_W` bits. An all-zero field selects the largest ratio, `2**FIELD_W`. When `USE_PRESCALE` is set, the top field bit switches in a fixed x`PRESCALE_MUL` prescale that multiplies the remaining low bits. A new code does not disturb the period that is already running. The channel holds the code as pending and raises `busy`. It moves the code into use on the wrap cycle of the current period, and `busy` drops at that point. While `busy` is high, further divisor writes are dropped.

The sequencing engine has four states:
- `DV_OFF`: the channel is gated and the counter is held at zero.
- `DV_OFF_PEND`: the channel is gated and a code is waiting. It moves the code into use on the next edge.
- `DV_RUN`: the counter is running.
- `DV_RUN_PEND`: the counter is running and a code is waiting for the end of the period.

The transitions are:
- enable: `DV_OFF` to `DV_RUN`.
- gate: `DV_RUN` to `DV_OFF`.
- park: from `DV_OFF`, or from `DV_RUN` when the enable drops in the same cycle, to `DV_OFF_PEND`.
- settle: `DV_OFF_PEND` to `DV_OFF` or `DV_RUN`, depending on the enable.
- queue: `DV_RUN` to `DV_RUN_PEND`.
- swap: `DV_RUN_PEND` to `DV_RUN` on the wrap cycle.
- abandon: `DV_RUN_PEND` to `DV_OFF`, which applies the code at once.

Top module: `clkdiv_channel`

## Requirements
- R1: After reset the enable bit is 0, the field reads 0, `busy` and `req_reject` are 0, and `clk_strobe` is low.
- R2: A write to address 1 stores the written data ANDed with the field mask (`2**FIELD_W-1`) as the field. A nonzero field without the prescale bit gives a ratio equal to its value. The stored field reads back at address 1.
- R3: A field of zero gives a ratio of `2**FIELD_W`: 64 with the default parameters, 32 when `FIELD_W`=5.
- R4: With `USE_PRESCALE`=1, a field whose top bit (bit 5 by default) is set gives a ratio of `PRESCALE_MUL` (64) times the low bits. When those low bits are zero, the ratio is `2**FIELD_W`.
- R5: While enabled with ratio N, `clk_strobe` is high for one cycle out of every N. The first strobe appears in the Nth cycle after the clock edge that captures the enable write.
- R6: Bit 0 written at address 0 is the enable. From the second cycle after it is cleared, `clk_strobe` stays low. After it is set again, the first strobe comes a full N cycles later.
- R7: An accepted divisor write sets `busy` in the next cycle. While the channel is running, the old ratio completes its current period, and the new ratio takes effect on that period's wrap cycle, where `busy` clears. While the channel is gated, `busy` lasts one cycle.
- R8: While `busy` is 1, writes to address 1 and address 2 are ignored.
- R9: A read at address 2 returns `busy` copied into both bit 4 and bit 3, with all other bits zero (0x18 when busy).
- R10: A ratio R written to address 2 is encoded as follows:
  - If R equals `2**FIELD_W`, the code is 0.
  - Otherwise, with the prescale enabled and R above `2**(FIELD_W-1)-1` (31), the code is 0x20 + R/64.
  - Otherwise the code is R.
- R11: If the encoded code is above the mask, `req_reject` is 1 in the cycle after the write, the field is unchanged, and `busy` stays 0.
- R12: A read at address 0 returns the enable in bit 0 and zero elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 enable, 1 raw field, 2 ratio request |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 2 | Read address: 0 enable, 1 field, 2 status |
| rd_data | output | DATA_W | Combinational read data |
| clk_strobe | output | 1 | Divided clock-enable strobe |
| busy | output | 1 | A new divisor is pending |
| req_reject | output | 1 | The previous ratio request could not be encoded |

## Verification
The hardest case to reach is a divisor write that lands in the middle of a running period. A second write then arrives while the first is still pending. To produce it, the stimulus first lines up with a strobe and counts a known number of cycles into the period before it writes. It then measures the rest of the old period exactly, checks that the dropped write left no trace, and times the first period at the new ratio. Large ratios that rely on the prescale bit are timed from the enable edge, so the full 1984-cycle period is checked.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

    typedef enum logic [1:0] {
        DV_OFF      = 2'd0,
        DV_OFF_PEND = 2'd1,
        DV_RUN      = 2'd2,
        DV_RUN_PEND = 2'd3
    } dv_state_t;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_FIELD = 2'd1;
    localparam logic [1:0] ADDR_RATIO = 2'd2;

    // status: busy mirrored into two adjacent bits starting here
    localparam int BUSY_LSB = 3;

endpackage

// File: rtl/clkdiv_decoder.sv
`timescale 1ns/1ps
module clkdiv_decoder #(
    parameter int FIELD_W      = 6,
    parameter bit USE_PRESCALE = 1'b1,
    parameter int PRESCALE_MUL = 64,
    parameter int CNT_W        = 11
) (
    input  logic [FIELD_W-1:0] field_i,
    output logic [CNT_W-1:0]   ratio_o
);
    localparam logic [CNT_W-1:0] FULL_RATIO = CNT_W'(2 ** FIELD_W);

    logic [CNT_W-1:0] raw;

    generate
        if (USE_PRESCALE) begin : g_pre
            logic [FIELD_W-2:0] low;
            always_comb begin
                low = field_i[FIELD_W-2:0];
                if (field_i[FIELD_W-1])
                    raw = CNT_W'(low) * CNT_W'(PRESCALE_MUL);
                else
                    raw = CNT_W'(field_i);
            end
        end else begin : g_plain
            always_comb raw = CNT_W'(field_i);
        end
    endgenerate

    always_comb ratio_o = (raw == '0) ? FULL_RATIO : raw;

endmodule

// File: rtl/clkdiv_encoder.sv
`timescale 1ns/1ps
module clkdiv_encoder #(
    parameter int DATA_W       = 16,
    parameter int FIELD_W      = 6,
    parameter bit USE_PRESCALE = 1'b1,
    parameter int PRESCALE_MUL = 64
) (
    input  logic [DATA_W-1:0]  ratio_i,
    output logic [FIELD_W-1:0] code_o,
    output logic               bad_o
);
    localparam logic [DATA_W-1:0] FULL_RATIO = DATA_W'(2 ** FIELD_W);
    localparam logic [DATA_W-1:0] FIELD_MASK = DATA_W'(2 ** FIELD_W - 1);
    localparam logic [DATA_W-1:0] PLAIN_MAX  = DATA_W'(2 ** (FIELD_W - 1) - 1);
    localparam logic [DATA_W-1:0] PRE_FLAG   = DATA_W'(2 ** (FIELD_W - 1));
    localparam logic [DATA_W-1:0] PRE_DIV    = DATA_W'(PRESCALE_MUL);

    logic [DATA_W-1:0] code_w;

    always_comb begin
        if (ratio_i == FULL_RATIO)
            code_w = '0;
        else if (USE_PRESCALE && (ratio_i > PLAIN_MAX))
            code_w = PRE_FLAG + (ratio_i / PRE_DIV);
        else
            code_w = ratio_i;
        bad_o  = (code_w > FIELD_MASK);
        code_o = code_w[FIELD_W-1:0];
    end

endmodule

// File: rtl/clkdiv_engine.sv
`timescale 1ns/1ps
module clkdiv_engine
    import clkdiv_pkg::*;
#(
    parameter int FIELD_W      = 6,
    parameter bit USE_PRESCALE = 1'b1,
    parameter int PRESCALE_MUL = 64,
    parameter int CNT_W        = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic               upd_i,
    input  logic [FIELD_W-1:0] upd_field_i,
    output logic               strobe_o,
    output logic               busy_o
);
    dv_state_t          st_q, st_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d, ratio;
    logic [FIELD_W-1:0] act_q, act_d, pend_q, pend_d;
    logic               running, tick;

    clkdiv_decoder #(
        .FIELD_W     (FIELD_W),
        .USE_PRESCALE(USE_PRESCALE),
        .PRESCALE_MUL(PRESCALE_MUL),
        .CNT_W       (CNT_W)
    ) u_dec (
        .field_i(act_q),
        .ratio_o(ratio)
    );

    always_comb begin
        running = (st_q == DV_RUN) || (st_q == DV_RUN_PEND);
        tick    = running && (cnt_q == (ratio - CNT_W'(1)));
    end

    // next-state and datapath
    always_comb begin
        st_d   = st_q;
        act_d  = act_q;
        pend_d = pend_q;
        cnt_d  = '0;
        unique case (st_q)
            DV_OFF: begin
                if (upd_i) begin
                    pend_d = upd_field_i;
                    st_d   = DV_OFF_PEND;          // park
                end else if (en_i) begin
                    st_d   = DV_RUN;               // enable
                end
            end
            DV_OFF_PEND: begin
                act_d = pend_q;                    // settle
                st_d  = en_i ? DV_RUN : DV_OFF;
            end
            DV_RUN: begin
                if (!en_i) begin
                    if (upd_i) begin
                        pend_d = upd_field_i;
                        st_d   = DV_OFF_PEND;      // park
                    end else begin
                        st_d   = DV_OFF;           // gate
                    end
                end else begin
                    cnt_d = tick ? '0 : cnt_q + CNT_W'(1);
                    if (upd_i) begin
                        pend_d = upd_field_i;
                        st_d   = DV_RUN_PEND;      // queue
                    end
                end
            end
            DV_RUN_PEND: begin
                if (!en_i) begin
                    act_d = pend_q;
                    st_d  = DV_OFF;                // abandon
                end else if (tick) begin
                    act_d = pend_q;
                    st_d  = DV_RUN;                // swap
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            default: st_d = DV_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= DV_OFF;
            cnt_q  <= '0;
            act_q  <= '0;
            pend_q <= '0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            act_q  <= act_d;
            pend_q <= pend_d;
        end
    end

    // outputs
    always_comb begin
        strobe_o = tick;
        unique case (st_q)
            DV_OFF_PEND, DV_RUN_PEND: busy_o = 1'b1;
            default:                  busy_o = 1'b0;
        endcase
    end

    // R7: a pending code survives every non-wrap running cycle
    a_r7_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == DV_RUN_PEND && en_i && !tick) |=> busy_o);

    // R5: after a wrap the counter restarts from zero
    a_r5_wrap_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_o && en_i) |=> (cnt_q == '0));

endmodule

// File: rtl/clkdiv_channel.sv
`timescale 1ns/1ps
module clkdiv_channel
    import clkdiv_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int FIELD_W      = 6,
    parameter bit USE_PRESCALE = 1'b1,
    parameter int PRESCALE_MUL = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              clk_strobe,
    output logic              busy,
    output logic              req_reject
);
    localparam int PRE_MAX   = PRESCALE_MUL * (2 ** (FIELD_W - 1) - 1);
    localparam int FULL      = 2 ** FIELD_W;
    localparam int MAX_RATIO = (USE_PRESCALE && PRE_MAX > FULL) ? PRE_MAX : FULL;
    localparam int CNT_W     = $clog2(MAX_RATIO + 1);

    logic               en_q, rej_q;
    logic [FIELD_W-1:0] field_q, enc_code, upd_field;
    logic               enc_bad, take_raw, take_req, upd;

    clkdiv_encoder #(
        .DATA_W      (DATA_W),
        .FIELD_W     (FIELD_W),
        .USE_PRESCALE(USE_PRESCALE),
        .PRESCALE_MUL(PRESCALE_MUL)
    ) u_enc (
        .ratio_i(wr_data),
        .code_o (enc_code),
        .bad_o  (enc_bad)
    );

    always_comb begin
        take_raw  = wr_en && (wr_addr == ADDR_FIELD) && !busy;
        take_req  = wr_en && (wr_addr == ADDR_RATIO) && !busy && !enc_bad;
        upd       = take_raw || take_req;
        upd_field = take_raw ? wr_data[FIELD_W-1:0] : enc_code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            field_q <= '0;
            rej_q   <= 1'b0;
        end else begin
            if (wr_en && (wr_addr == ADDR_CTRL))
                en_q <= wr_data[0];
            if (upd)
                field_q <= upd_field;
            rej_q <= wr_en && (wr_addr == ADDR_RATIO) && enc_bad;
        end
    end

    clkdiv_engine #(
        .FIELD_W     (FIELD_W),
        .USE_PRESCALE(USE_PRESCALE),
        .PRESCALE_MUL(PRESCALE_MUL),
        .CNT_W       (CNT_W)
    ) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_q),
        .upd_i      (upd),
        .upd_field_i(upd_field),
        .strobe_o   (clk_strobe),
        .busy_o     (busy)
    );

    always_comb begin
        unique case (rd_addr)
            ADDR_CTRL:  rd_data = DATA_W'(en_q);
            ADDR_FIELD: rd_data = DATA_W'(field_q);
            ADDR_RATIO: rd_data = DATA_W'({busy, busy}) << BUSY_LSB;
            default:    rd_data = '0;
        endcase
    end

    assign req_reject = rej_q;

    // R6: strobe is quiet once the gate has been low for a full cycle
    a_r6_gate_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && $past(!en_q)) |-> !clk_strobe);

    // R8: divisor writes while busy leave the field alone
    a_r8_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && (wr_addr == ADDR_FIELD || wr_addr == ADDR_RATIO))
        |=> $stable(field_q));

    // R11: an unencodable request flags and keeps the field
    a_r11_reject_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_RATIO && enc_bad) |=> (req_reject && $stable(field_q)));

    // R7: an accepted update always shows busy next cycle
    a_r7_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> busy);

endmodule

// File: tb/test_clkdiv_channel.sv
`timescale 1ns/1ps
module test_clkdiv_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en_w = 1'b0, wr_en_n = 1'b0;
    logic [1:0]  wr_addr = 2'd0, rd_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [15:0] rd_w, rd_n;
    logic        stb_w, stb_n, busy_w, busy_n, rej_w, rej_n;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    clkdiv_channel i_clkdiv_channel (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_w), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_w),
        .clk_strobe(stb_w), .busy(busy_w), .req_reject(rej_w)
    );

    clkdiv_channel #(.FIELD_W(5), .USE_PRESCALE(1'b0)) i_clkdiv_channel_narrow (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_n), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_n),
        .clk_strobe(stb_n), .busy(busy_n), .req_reject(rej_n)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input bit nar, input logic [1:0] a, input logic [15:0] d);
        wr_addr = a;
        wr_data = d;
        if (nar) wr_en_n = 1'b1; else wr_en_w = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en_w = 1'b0;
        wr_en_n = 1'b0;
    endtask

    task automatic rd(input bit nar, input logic [1:0] a, output int v);
        rd_addr = a;
        #1;
        v = nar ? int'(rd_n) : int'(rd_w);
    endtask

    task automatic wait_stb(input bit nar, output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!(nar ? stb_n : stb_w) && k < 5000);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // gate, program, re-enable, then time first period and one gap
    task automatic prog_run(input bit nar, input logic [1:0] a, input logic [15:0] d,
                            input int exp, input string tag);
        int k;
        wr(nar, 2'd0, 16'd0);
        idle(2);
        wr(nar, a, d);
        idle(2);
        wr(nar, 2'd0, 16'd1);
        wait_stb(nar, k);
        check(k == exp, {tag, " first"}, k, exp);
        if (exp < 1000) begin
            wait_stb(nar, k);
            check(k == exp, {tag, " gap"}, k, exp);
        end
    endtask

    task automatic t_reset;
        int v;
        check(stb_w == 0 && stb_n == 0, "R1 strobe", int'(stb_w), 0);
        check(busy_w == 0 && rej_w == 0, "R1 busy/reject", int'(busy_w), 0);
        rd(0, 2'd0, v); check(v == 0, "R1 enable", v, 0);
        rd(0, 2'd1, v); check(v == 0, "R1 field", v, 0);
        rd(1, 2'd1, v); check(v == 0, "R1 narrow field", v, 0);
        rd(0, 2'd2, v); check(v == 0, "R9 idle status", v, 0);
    endtask

    task automatic t_default;
        int v, k;
        wr(0, 2'd0, 16'hFFFF);
        rd(0, 2'd0, v); check(v == 1, "R12 enable readback", v, 1);
        wait_stb(0, k); check(k == 64, "R3 R5 wide first strobe", k, 64);
        wait_stb(0, k); check(k == 64, "R3 R5 wide gap", k, 64);
        wr(1, 2'd0, 16'd1);
        wait_stb(1, k); check(k == 32, "R3 narrow first strobe", k, 32);
        @(negedge clk);
        check(stb_n == 0, "R5 strobe one cycle", int'(stb_n), 0);
    endtask

    task automatic t_raw;
        int v;
        prog_run(0, 2'd1, 16'hFFC5, 5, "R2 masked raw 5");
        rd(0, 2'd1, v); check(v == 5, "R2 field readback", v, 5);
        prog_run(0, 2'd1, 16'd1, 1, "R2 ratio 1");
        prog_run(0, 2'd1, 16'h22, 128, "R4 prescale 0x22");
        prog_run(0, 2'd1, 16'h20, 64, "R4 prescale zero low");
        prog_run(0, 2'd1, 16'h3F, 1984, "R4 prescale max");
        prog_run(1, 2'd1, 16'd0, 32, "R3 narrow zero");
    endtask

    task automatic t_encode;
        int v;
        prog_run(0, 2'd2, 16'd128, 128, "R10 req 128");
        rd(0, 2'd1, v); check(v == 'h22, "R10 code 128", v, 'h22);
        prog_run(0, 2'd2, 16'd40, 64, "R10 req 40");
        rd(0, 2'd1, v); check(v == 'h20, "R10 code 40", v, 'h20);
        prog_run(0, 2'd2, 16'd7, 7, "R10 req 7");
        rd(0, 2'd1, v); check(v == 7, "R10 code 7", v, 7);
        prog_run(0, 2'd2, 16'd64, 64, "R10 req 64");
        rd(0, 2'd1, v); check(v == 0, "R10 code 64", v, 0);
        wr(0, 2'd2, 16'd2047);
        idle(2);
        rd(0, 2'd1, v); check(v == 'h3F, "R10 code 2047", v, 'h3F);
        prog_run(1, 2'd2, 16'd32, 32, "R10 narrow req 32");
        rd(1, 2'd1, v); check(v == 0, "R10 narrow code 32", v, 0);
    endtask

    task automatic t_reject;
        int v;
        wr(0, 2'd0, 16'd0);
        idle(2);
        wr(0, 2'd1, 16'd9);
        idle(2);
        wr(0, 2'd2, 16'd2048);
        check(rej_w == 1, "R11 reject pulse", int'(rej_w), 1);
        check(busy_w == 0, "R11 no busy", int'(busy_w), 0);
        @(negedge clk);
        check(rej_w == 0, "R11 pulse ends", int'(rej_w), 0);
        rd(0, 2'd1, v); check(v == 9, "R11 field kept", v, 9);
        wr(1, 2'd2, 16'd33);
        check(rej_n == 1, "R11 narrow reject", int'(rej_n), 1);
        rd(1, 2'd1, v); check(v == 0, "R11 narrow field kept", v, 0);
    endtask

    task automatic t_midchange;
        int v, k;
        prog_run(0, 2'd1, 16'd10, 10, "R7 base 10");
        idle(3);
        wr(0, 2'd1, 16'd4);
        check(busy_w == 1, "R7 busy set", int'(busy_w), 1);
        rd(0, 2'd2, v); check(v == 'h18, "R9 busy status", v, 'h18);
        wr(0, 2'd1, 16'd7);
        rd(0, 2'd1, v); check(v == 4, "R8 write ignored", v, 4);
        wait_stb(0, k); check(k == 5, "R7 old period completes", k, 5);
        check(busy_w == 1, "R7 busy until wrap", int'(busy_w), 1);
        wait_stb(0, k); check(k == 4, "R7 R8 new ratio", k, 4);
        check(busy_w == 0, "R7 busy cleared", int'(busy_w), 0);
        rd(0, 2'd2, v); check(v == 0, "R9 status clear", v, 0);
    endtask

    task automatic t_gate;
        int k, hits;
        wait_stb(0, k);
        wr(0, 2'd0, 16'd0);
        hits = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (stb_w) hits++;
        end
        check(hits == 0, "R6 gated quiet", hits, 0);
        wr(0, 2'd1, 16'd6);
        check(busy_w == 1, "R7 gated busy", int'(busy_w), 1);
        @(negedge clk);
        check(busy_w == 0, "R7 gated busy one cycle", int'(busy_w), 0);
        wr(0, 2'd0, 16'd1);
        wait_stb(0, k); check(k == 6, "R6 full period on re-enable", k, 6);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_default();
        t_raw();
        t_encode();
        t_reject();
        t_midchange();
        t_gate();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1500000;
        total++;
        bad++;
        $display("FAIL watchdog act=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule